// File: doc/BRIEF.md
# Strap-Gated 64-bit Prefetchable Window Decoder

This block holds the base of one 64-bit prefetchable memory window with 1 MB granularity for a bus bridge. Software reaches it through a simple configuration port that reads and writes dwords. The base is split into two dwords. The lower dword carries base bits 31:20 and a fixed type tag in its low bits. The upper dword, at the next dword index, carries base bits 63:32.

The same base decodes memory addresses that arrive from both sides of the bridge. A primary-side access inside the window is claimed for forwarding. A secondary-side access inside the same window is marked to be ignored, so the bridge does not pass it back.

A static enable strap gates the whole feature. With the strap low, both dwords read as zero, configuration writes are dropped and neither decode output ever fires.

Top module: `win_bar64_top`

## Requirements
- R1: After reset with the strap high, the lower dword reads 0x0000000C and the upper dword reads 0x00000000.
- R2: With the strap low, both dwords read 0x00000000, and writes made then leave the stored contents unchanged; this shows once the strap is high again.
- R3: In the lower dword only bits 31:20 are writable. Bits 19:4 always read 0, bit 3 reads 1, bits 2:1 read binary 10 and bit 0 reads 0, whatever data is written.
- R4: The upper dword sits at dword index LO_DW+1 and all 32 bits are writable. Byte-enable bit k gates data bits 8k+7:8k in both dwords.
- R5: A primary strobe whose address bits 63:20 equal {upper dword, lower bits 31:20} drives pri_claim_o high for exactly the cycle after the strobe.
- R6: A secondary strobe that hits the same window drives sec_ignore_o high for exactly the cycle after the strobe.
- R7: An address that differs in any of bits 63:20 does not raise the output for its side. A cycle with no strobe does not raise it either. Address bits 19:0 never affect the decision.
- R8: With the strap low, pri_claim_o and sec_ignore_o stay low even for matching addresses.
- R9: Primary and secondary strobes in the same cycle are decoded independently against the same base.
- R10: Dword indices other than the two window dwords read 0x00000000, and writes to them change neither dword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en_i | input | 1 | Static feature enable strap |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration dword index |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for the addressed dword (combinational) |
| pri_valid_i | input | 1 | Primary-side address strobe |
| pri_addr_i | input | 64 | Primary-side memory address |
| sec_valid_i | input | 1 | Secondary-side address strobe |
| sec_addr_i | input | 64 | Secondary-side memory address |
| pri_claim_o | output | 1 | Registered claim/forward decision for the primary side |
| sec_ignore_o | output | 1 | Registered ignore decision for the secondary side |

## Verification
The two decode paths can fire in the same clock cycle, because each bus side strobes its own address. The bench raises both strobes in one cycle in three cases: both addresses hit, only the primary hits, and only the secondary hits. On the following cycle it checks each output on its own against the expected value for its own address. A configuration write can also land in the same cycle as a strobe. The bench checks that this strobe is judged against the base that was stored before the write.

// File: rtl/win_bar_pkg.sv
package win_bar_pkg;

    localparam int DWORD_W   = 32;
    localparam int ADDR_W    = 64;
    localparam int WIN_LOG2  = 20;
    localparam int LANES     = DWORD_W / 8;
    localparam int BASE_W    = ADDR_W - WIN_LOG2;
    localparam int BASE_LO_W = DWORD_W - WIN_LOG2;

    // writable field of the lower dword
    localparam logic [DWORD_W-1:0] LO_WMASK =
        ~((DWORD_W'(1) << WIN_LOG2) - DWORD_W'(1));

    // fixed type tag: prefetchable, 64-bit decoder, memory space
    localparam logic [DWORD_W-1:0] LO_TAG = DWORD_W'(32'h0000_000C);

    typedef struct packed {
        logic [DWORD_W-1:0] lo;
        logic [DWORD_W-1:0] hi;
    } bar_regs_t;

    typedef struct packed {
        logic hit;
    } dec_state_t;

endpackage

// File: rtl/win_bar_regs.sv
module win_bar_regs
    import win_bar_pkg::*;
#(
    parameter int CFG_AW = 6,
    parameter int LO_DW  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_en_i,
    input  logic                 cfg_wr_i,
    input  logic [CFG_AW-1:0]    cfg_addr_i,
    input  logic [LANES-1:0]     cfg_be_i,
    input  logic [DWORD_W-1:0]   cfg_wdata_i,
    output logic [DWORD_W-1:0]   lo_q_o,
    output logic [DWORD_W-1:0]   hi_q_o,
    output logic [BASE_W-1:0]    base_o
);

    localparam logic [CFG_AW-1:0] LO_IDX = CFG_AW'(LO_DW);
    localparam logic [CFG_AW-1:0] HI_IDX = CFG_AW'(LO_DW + 1);

    bar_regs_t          regs_d, regs_q;
    logic [DWORD_W-1:0] lane_mask;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{cfg_be_i[b]}};
    end

    always_comb begin
        logic [DWORD_W-1:0] lo_m;
        regs_d = regs_q;
        lo_m   = lane_mask & LO_WMASK;
        if (cfg_wr_i && strap_en_i) begin
            if (cfg_addr_i == LO_IDX) begin
                regs_d.lo = (regs_q.lo & ~lo_m) | (cfg_wdata_i & lo_m);
            end
            if (cfg_addr_i == HI_IDX) begin
                regs_d.hi = (regs_q.hi & ~lane_mask) | (cfg_wdata_i & lane_mask);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign lo_q_o = regs_q.lo;
    assign hi_q_o = regs_q.hi;
    assign base_o = {regs_q.hi, regs_q.lo[DWORD_W-1:WIN_LOG2]};

endmodule

// File: rtl/win_bar_rdmux.sv
module win_bar_rdmux
    import win_bar_pkg::*;
#(
    parameter int CFG_AW = 6,
    parameter int LO_DW  = 4
) (
    input  logic                 strap_en_i,
    input  logic [CFG_AW-1:0]    cfg_addr_i,
    input  logic [DWORD_W-1:0]   lo_q_i,
    input  logic [DWORD_W-1:0]   hi_q_i,
    output logic [DWORD_W-1:0]   rdata_o
);

    localparam logic [CFG_AW-1:0] LO_IDX = CFG_AW'(LO_DW);
    localparam logic [CFG_AW-1:0] HI_IDX = CFG_AW'(LO_DW + 1);

    always_comb begin
        rdata_o = '0;
        if (strap_en_i) begin
            if (cfg_addr_i == LO_IDX) begin
                rdata_o = (lo_q_i & LO_WMASK) | LO_TAG;
            end else if (cfg_addr_i == HI_IDX) begin
                rdata_o = hi_q_i;
            end
        end
    end

endmodule

// File: rtl/win_bar_side_dec.sv
module win_bar_side_dec
    import win_bar_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic               valid_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [BASE_W-1:0]  base_i,
    output logic               hit_o
);

    dec_state_t dec_d, dec_q;
    logic       unused_low_bits;

    // offset bits inside the window play no part in the decision
    assign unused_low_bits = ^addr_i[WIN_LOG2-1:0];

    always_comb begin
        dec_d     = dec_q;
        dec_d.hit = enable_i && valid_i && (addr_i[ADDR_W-1:WIN_LOG2] == base_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign hit_o = dec_q.hit;

endmodule

// File: rtl/win_bar64_top.sv
module win_bar64_top
    import win_bar_pkg::*;
#(
    parameter int CFG_AW = 6,
    parameter int LO_DW  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_en_i,
    input  logic                cfg_wr_i,
    input  logic [5:0]          cfg_addr_i,
    input  logic [3:0]          cfg_be_i,
    input  logic [31:0]         cfg_wdata_i,
    output logic [31:0]         cfg_rdata_o,
    input  logic                pri_valid_i,
    input  logic [63:0]         pri_addr_i,
    input  logic                sec_valid_i,
    input  logic [63:0]         sec_addr_i,
    output logic                pri_claim_o,
    output logic                sec_ignore_o
);

    localparam int SIDES = 2;

    logic [DWORD_W-1:0] lo_q, hi_q;
    logic [BASE_W-1:0]  base;
    logic [SIDES-1:0]   side_valid;
    logic [ADDR_W-1:0]  side_addr [SIDES];
    logic [SIDES-1:0]   side_hit;

    win_bar_regs #(.CFG_AW(CFG_AW), .LO_DW(LO_DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_en_i (strap_en_i),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_addr_i (cfg_addr_i),
        .cfg_be_i   (cfg_be_i),
        .cfg_wdata_i(cfg_wdata_i),
        .lo_q_o     (lo_q),
        .hi_q_o     (hi_q),
        .base_o     (base)
    );

    win_bar_rdmux #(.CFG_AW(CFG_AW), .LO_DW(LO_DW)) u_rdmux (
        .strap_en_i (strap_en_i),
        .cfg_addr_i (cfg_addr_i),
        .lo_q_i     (lo_q),
        .hi_q_i     (hi_q),
        .rdata_o    (cfg_rdata_o)
    );

    // side 0 = primary (claim), side 1 = secondary (ignore)
    assign side_valid   = {sec_valid_i, pri_valid_i};
    assign side_addr[0] = pri_addr_i;
    assign side_addr[1] = sec_addr_i;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        win_bar_side_dec u_dec (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable_i (strap_en_i),
            .valid_i  (side_valid[s]),
            .addr_i   (side_addr[s]),
            .base_i   (base),
            .hit_o    (side_hit[s])
        );
    end

    assign pri_claim_o  = side_hit[0];
    assign sec_ignore_o = side_hit[1];

endmodule

// File: rtl/win_bar64_chk.sv
module win_bar64_chk #(
    parameter int LO_DW = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        strap_en_i,
    input logic [5:0]  cfg_addr_i,
    input logic [31:0] cfg_rdata_o,
    input logic        pri_valid_i,
    input logic        sec_valid_i,
    input logic        pri_claim_o,
    input logic        sec_ignore_o
);

    assert_strap_low_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_en_i |-> cfg_rdata_o == 32'h0);

    assert_lo_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_en_i && cfg_addr_i == 6'(LO_DW)) |-> cfg_rdata_o[19:0] == 20'h0000C);

    assert_claim_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pri_claim_o |-> $past(pri_valid_i));

    assert_ignore_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_ignore_o |-> $past(sec_valid_i));

    assert_strap_low_no_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_en_i |=> (!pri_claim_o && !sec_ignore_o));

    assert_other_index_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr_i != 6'(LO_DW) && cfg_addr_i != 6'(LO_DW + 1)) |-> cfg_rdata_o == 32'h0);

endmodule

bind win_bar64_top win_bar64_chk #(.LO_DW(LO_DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_en_i  (strap_en_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_rdata_o (cfg_rdata_o),
    .pri_valid_i (pri_valid_i),
    .sec_valid_i (sec_valid_i),
    .pri_claim_o (pri_claim_o),
    .sec_ignore_o(sec_ignore_o)
);

// File: tb/tb_win_bar64_top.sv
module tb_win_bar64_top;

    localparam logic [5:0] LO = 6'd4;
    localparam logic [5:0] HI = 6'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_en_i = 1'b1;
    logic        cfg_wr_i = 1'b0;
    logic [5:0]  cfg_addr_i = '0;
    logic [3:0]  cfg_be_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] cfg_rdata_o;
    logic        pri_valid_i = 1'b0;
    logic [63:0] pri_addr_i = '0;
    logic        sec_valid_i = 1'b0;
    logic [63:0] sec_addr_i = '0;
    logic        pri_claim_o;
    logic        sec_ignore_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    win_bar64_top dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr_i = a;
        #1 d = cfg_rdata_o;
    endtask

    // drive strobes for one cycle, return outputs seen in the following cycle
    task automatic decode(input logic pv, input logic [63:0] pa, input logic sv,
                          input logic [63:0] sa, output logic pc, output logic si);
        @(negedge clk);
        pri_valid_i = pv; pri_addr_i = pa; sec_valid_i = sv; sec_addr_i = sa;
        @(negedge clk);
        pri_valid_i = 1'b0; sec_valid_i = 1'b0;
        pc = pri_claim_o; si = sec_ignore_o;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        cfg_read(LO, d); chk("R1 lo reset", 64'(d), 64'h0000000C);
        cfg_read(HI, d); chk("R1 hi reset", 64'(d), 64'h0);
        chk("R1 outputs idle", {62'h0, pri_claim_o, sec_ignore_o}, 64'h0);
    endtask

    task automatic t_fields();
        logic [31:0] d;
        cfg_write(LO, 4'hF, 32'hFFFF_FFFF);
        cfg_read(LO, d); chk("R3 lo all ones", 64'(d), 64'hFFF0000C);
        cfg_write(LO, 4'hF, 32'h0000_0000);
        cfg_read(LO, d); chk("R3 lo zeros keeps tag", 64'(d), 64'h0000000C);
        cfg_write(LO, 4'b0100, 32'hFFFF_FFFF);
        cfg_read(LO, d); chk("R4 lo lane2 only", 64'(d), 64'h00F0000C);
        cfg_write(HI, 4'b0101, 32'h1234_5678);
        cfg_read(HI, d); chk("R4 hi lanes 0 and 2", 64'(d), 64'h00340078);
        cfg_write(HI, 4'hF, 32'h0000_0001);
        cfg_write(LO, 4'hF, 32'hABC0_0000);
        cfg_read(HI, d); chk("R4 hi full", 64'(d), 64'h1);
        cfg_read(LO, d); chk("R3 lo base", 64'(d), 64'hABC0000C);
    endtask

    task automatic t_other_index();
        logic [31:0] d;
        cfg_write(6'd6, 4'hF, 32'hDEAD_BEEF);
        cfg_write(6'd3, 4'hF, 32'hDEAD_BEEF);
        cfg_read(6'd6, d); chk("R10 idx6 zero", 64'(d), 64'h0);
        cfg_read(LO, d);   chk("R10 lo untouched", 64'(d), 64'hABC0000C);
        cfg_read(HI, d);   chk("R10 hi untouched", 64'(d), 64'h1);
    endtask

    task automatic t_decode();
        logic pc, si;
        decode(1, 64'h1_ABCF_FFFF, 0, 0, pc, si);
        chk("R5 primary hit", {pc, si}, 2'b10);
        @(negedge clk);
        chk("R5 one cycle only", {pri_claim_o, sec_ignore_o}, 2'b00);
        decode(0, 0, 1, 64'h1_ABC0_0000, pc, si);
        chk("R6 secondary hit", {pc, si}, 2'b01);
        @(negedge clk);
        chk("R6 one cycle only", {pri_claim_o, sec_ignore_o}, 2'b00);
        decode(1, 64'h1_ABD0_0000, 1, 64'h0_ABC0_0000, pc, si);
        chk("R7 misses", {pc, si}, 2'b00);
        decode(0, 64'h1_ABC0_0000, 0, 64'h1_ABC0_0000, pc, si);
        chk("R7 no strobe", {pc, si}, 2'b00);
        decode(1, 64'h8001_ABC1_2345, 0, 0, pc, si);
        chk("R7 top bit differs", {pc, si}, 2'b00);
    endtask

    task automatic t_both_sides();
        logic pc, si;
        decode(1, 64'h1_ABC1_2345, 1, 64'h1_ABC5_4321, pc, si);
        chk("R9 both hit", {pc, si}, 2'b11);
        decode(1, 64'h1_ABC0_0000, 1, 64'h1_ABB0_0000, pc, si);
        chk("R9 primary only", {pc, si}, 2'b10);
        decode(1, 64'h2_ABC0_0000, 1, 64'h1_ABCF_FFFF, pc, si);
        chk("R9 secondary only", {pc, si}, 2'b01);
        // write and strobe in the same cycle: old base is used
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_addr_i = LO; cfg_be_i = 4'hF; cfg_wdata_i = 32'h5550_0000;
        pri_valid_i = 1'b1; pri_addr_i = 64'h1_ABC0_0000;
        sec_valid_i = 1'b1; sec_addr_i = 64'h1_5550_0000;
        @(negedge clk);
        cfg_wr_i = 1'b0; pri_valid_i = 1'b0; sec_valid_i = 1'b0;
        chk("R9 old base during write", {pri_claim_o, sec_ignore_o}, 2'b10);
        decode(1, 64'h1_5550_0000, 1, 64'h1_ABC0_0000, pc, si);
        chk("R5 new base", {pc, si}, 2'b10);
    endtask

    task automatic t_strap_low();
        logic [31:0] d;
        logic pc, si;
        @(negedge clk); strap_en_i = 1'b0;
        cfg_read(LO, d); chk("R2 lo reads zero", 64'(d), 64'h0);
        cfg_read(HI, d); chk("R2 hi reads zero", 64'(d), 64'h0);
        cfg_write(LO, 4'hF, 32'h1230_0000);
        cfg_write(HI, 4'hF, 32'h0000_0009);
        decode(1, 64'h1_5550_0000, 1, 64'h1_5550_0000, pc, si);
        chk("R8 strap low no decode", {pc, si}, 2'b00);
        @(negedge clk); strap_en_i = 1'b1;
        cfg_read(LO, d); chk("R2 lo kept", 64'(d), 64'h5550000C);
        cfg_read(HI, d); chk("R2 hi kept", 64'(d), 64'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_other_index();
        t_decode();
        t_both_sides();
        t_strap_low();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule